// File: doc/BRIEF.md
# SPI Register-Access Target with Bit-Interleaved Parity

This block is an SPI target that gives an SPI host byte-wide read and write access to a 16-bit address space. The address space sits behind a simple synchronous memory port. A transaction runs while chip select is low. The first byte is a command. It is followed by a big-endian 16-bit start address. A write then streams data bytes into consecutive addresses. A read takes one dummy byte and then streams data back, starting at the given address, until chip select rises. All bytes travel most significant bit first.

The SPI clock polarity and phase come from a two-bit strap input. The block latches it at the start of every transaction, so all four SPI modes can be used at run time. A second configuration input turns on a checked framing mode, latched the same way. In that mode the frame is fixed at two data bytes plus an XOR check byte, taken over the address and data bytes. A write whose check byte does not match is discarded, and the block pulses an error output. A read returns its own check byte after the two data bytes.

The SPI pins are sampled with the system clock through synchronizers. The SPI clock must therefore run well below the system clock. The bench uses a ratio of 1:16.

Top module: `spi_regacc`

## Requirements
- R1: `cfg_mode` is latched when chip select falls and selects {CPOL,CPHA} = {cfg_mode[1],cfg_mode[0]}. Value 00 is mode 0, 01 is mode 1, 10 is mode 2 and 11 is mode 3. In every mode, MOSI is sampled and MISO is shifted MSB first on the edges that mode defines.
- R2: Command 0x02 is a write. Its next two bytes are address bits 15..8 and then bits 7..0. Each following byte is written to the current address, which then increments by one and wraps from 0xFFFF to 0x0000.
- R3: Commands 0x03 and 0x0B both start a read and behave the same way. The byte after the two address bytes is a dummy, and MISO returns 0x00 during it. From the next byte on, MISO returns the memory byte at the start address, then at each following address, until chip select rises.
- R4: Any other command byte causes no memory read or write for the rest of the transaction, and MISO returns 0x00 for every byte of it.
- R5: MISO is 0 while chip select is high.
- R6: With `cfg_bip` latched at 1, a write carries exactly two data bytes, D0 and D1, followed by a check byte. When the check equals ADDR_HI^ADDR_LO^D0^D1, D0 is written to the address and D1 to the address plus one, on two consecutive cycles. Bytes after the check byte are ignored.
- R7: In checked mode, a write whose check byte does not match performs no memory write. `parity_err` is then high for exactly one cycle.
- R8: In checked mode, a read returns D0, D1 and then the check ADDR_HI^ADDR_LO^DUMMY^D0^D1. After that, MISO returns 0x00 until chip select rises.
- R9: The memory port has a one-cycle read latency: `mem_rdata` is used the cycle after `mem_rd_en`. A read and a write are never requested in the same cycle. After reset, `mem_wr_en`, `mem_rd_en`, `parity_err` and `spi_miso` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | SPI mode strap {CPOL,CPHA}, latched when chip select falls |
| cfg_bip | input | 1 | Checked framing enable, latched when chip select falls |
| spi_sclk | input | 1 | SPI clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| mem_wr_en | output | 1 | Memory write strobe, one cycle per byte |
| mem_rd_en | output | 1 | Memory read strobe, one cycle per byte |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd_en` |
| parity_err | output | 1 | One-cycle pulse when a checked write fails its check |

## Verification
The assertions check, on every cycle, the properties of the memory port and the error pulse. A read and a write never overlap. Read strobes last one cycle. The two writes of a checked frame go to consecutive addresses. An error pulse lasts one cycle and never comes with a write. MISO stays low while chip select is held high. The bench scenarios are needed for the rest: the bit order in each of the four SPI modes, address increment and wrap, the equivalence of the two read commands, and the values of the check byte. The bench also shows that an unknown command or a failed check leaves the memory untouched, which no single-cycle property can capture.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] CMD_WRITE     = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_READ      = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_READ_ALT  = 8'h0B;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CMD, PH_ADDR_HI, PH_ADDR_LO, PH_DUMMY,
    PH_WDATA, PH_RDATA, PH_CHECK, PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {CMD_NONE, CMD_WR, CMD_RD} cmd_kind_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  function automatic spi_mode_t decode_mode(input logic [1:0] strap);
    spi_mode_t m;
    m.cpol = strap[1];
    m.cpha = strap[0];
    return m;
  endfunction

  function automatic cmd_kind_t classify_cmd(input logic [BYTE_W-1:0] b);
    if (b == CMD_WRITE) return CMD_WR;
    if (b == CMD_READ || b == CMD_READ_ALT) return CMD_RD;
    return CMD_NONE;
  endfunction

  // Column-wise parity fold: each bit of the accumulator tracks one bit position.
  function automatic logic [BYTE_W-1:0] bip_fold(input logic [BYTE_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    return acc ^ b;
  endfunction
endpackage

// File: rtl/spi_regacc_edge.sv
module spi_regacc_edge
  import spi_regacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       cs_act,
  output logic       cs_start,
  output logic       sample_evt,
  output logic       shift_evt,
  output logic       mosi_s
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] cs_q, sck_q, mosi_q;
  logic         sck_prev, cs_act_d;
  spi_mode_t    mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= '1;
      sck_q    <= '0;
      mosi_q   <= '0;
      sck_prev <= 1'b0;
      cs_act_d <= 1'b0;
      mode_q   <= '0;
    end else begin
      cs_q     <= {cs_q[TOP-1:0], cs_n};
      sck_q    <= {sck_q[TOP-1:0], sclk};
      mosi_q   <= {mosi_q[TOP-1:0], mosi};
      sck_prev <= sck_q[TOP];
      cs_act_d <= cs_act;
      if (cs_start) mode_q <= decode_mode(strap);
    end
  end

  logic rise, fall, lead, trail;

  assign cs_act   = ~cs_q[TOP];
  assign cs_start = cs_act & ~cs_act_d;
  assign mosi_s   = mosi_q[TOP];
  assign rise     = sck_q[TOP] & ~sck_prev;
  assign fall     = ~sck_q[TOP] & sck_prev;
  assign lead     = mode_q.cpol ? fall : rise;
  assign trail    = mode_q.cpol ? rise : fall;

  assign sample_evt = cs_act & ~cs_start & (mode_q.cpha ? trail : lead);
  assign shift_evt  = cs_act & ~cs_start & (mode_q.cpha ? lead : trail);
endmodule

// File: rtl/spi_regacc_shift.sv
module spi_regacc_shift
  import spi_regacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              sample_evt,
  input  logic              shift_evt,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_load,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      tx_load   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      tx_load   <= 1'b0;
      if (cs_start) begin
        bit_cnt <= '0;
        rx_sr   <= '0;
        tx_sr   <= '0;
      end else if (cs_act) begin
        if (sample_evt) begin
          rx_sr <= {rx_sr[BYTE_W-2:0], mosi_s};
          if (bit_cnt == LAST_BIT) begin
            bit_cnt   <= '0;
            rx_byte   <= {rx_sr[BYTE_W-2:0], mosi_s};
            byte_done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (shift_evt) begin
          // A shift edge seen at a byte boundary starts the next outgoing byte.
          if (bit_cnt == '0) begin
            tx_sr   <= tx_byte;
            tx_load <= 1'b1;
          end else begin
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso = cs_act & tx_sr[BYTE_W-1];
endmodule

// File: rtl/spi_regacc_ctrl.sv
module spi_regacc_ctrl
  import spi_regacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              bip_mode,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              parity_err,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              bip_active
);
  phase_t            phase;
  logic              is_rd, bip_q, wcnt, wr_en, rd_req, rd_vld, wr2_pend, perr;
  logic [1:0]        rcnt;
  logic [ADDR_W-1:0] addr, wr_addr;
  logic [BYTE_W-1:0] bip, wd0, wd1, tx_next, wr_data;
  cmd_kind_t         kind;

  assign kind = classify_cmd(rx_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      is_rd    <= 1'b0;
      bip_q    <= 1'b0;
      wcnt     <= 1'b0;
      rcnt     <= '0;
      addr     <= '0;
      wr_addr  <= '0;
      bip      <= '0;
      wd0      <= '0;
      wd1      <= '0;
      tx_next  <= '0;
      wr_data  <= '0;
      wr_en    <= 1'b0;
      rd_req   <= 1'b0;
      rd_vld   <= 1'b0;
      wr2_pend <= 1'b0;
      perr     <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      rd_req <= 1'b0;
      perr   <= 1'b0;
      rd_vld <= rd_req;
      if (rd_vld) tx_next <= mem_rdata;
      if (wr2_pend) begin
        wr_en    <= 1'b1;
        wr_addr  <= addr + 1'b1;
        wr_data  <= wd1;
        wr2_pend <= 1'b0;
      end
      if (cs_start) begin
        phase   <= PH_CMD;
        bip_q   <= bip_mode;
        bip     <= '0;
        tx_next <= '0;
        wcnt    <= 1'b0;
        rcnt    <= '0;
      end else if (!cs_act) begin
        phase <= PH_IDLE;
      end else begin
        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              is_rd <= (kind == CMD_RD);
              phase <= (kind == CMD_NONE) ? PH_SKIP : PH_ADDR_HI;
            end
            PH_ADDR_HI: begin
              addr[ADDR_W-1:BYTE_W] <= rx_byte;
              bip   <= bip_fold(bip, rx_byte);
              phase <= PH_ADDR_LO;
            end
            PH_ADDR_LO: begin
              addr[BYTE_W-1:0] <= rx_byte;
              bip <= bip_fold(bip, rx_byte);
              if (is_rd) begin
                rd_req <= 1'b1;
                phase  <= PH_DUMMY;
              end else begin
                phase <= PH_WDATA;
              end
            end
            PH_DUMMY: begin
              bip   <= bip_fold(bip, rx_byte);
              phase <= PH_RDATA;
            end
            PH_WDATA: begin
              if (!bip_q) begin
                wr_en   <= 1'b1;
                wr_addr <= addr;
                wr_data <= rx_byte;
                addr    <= addr + 1'b1;
              end else begin
                bip <= bip_fold(bip, rx_byte);
                if (!wcnt) begin
                  wd0  <= rx_byte;
                  wcnt <= 1'b1;
                end else begin
                  wd1   <= rx_byte;
                  phase <= PH_CHECK;
                end
              end
            end
            PH_CHECK: begin
              if (rx_byte == bip) begin
                wr_en    <= 1'b1;
                wr_addr  <= addr;
                wr_data  <= wd0;
                wr2_pend <= 1'b1;
              end else begin
                perr <= 1'b1;
              end
              phase <= PH_SKIP;
            end
            default: ;
          endcase
        end
        if (tx_load && phase == PH_RDATA) begin
          if (!bip_q) begin
            addr   <= addr + 1'b1;
            rd_req <= 1'b1;
          end else begin
            unique case (rcnt)
              2'd0: begin
                bip    <= bip_fold(bip, tx_next);
                addr   <= addr + 1'b1;
                rd_req <= 1'b1;
                rcnt   <= 2'd1;
              end
              2'd1: begin
                bip     <= bip_fold(bip, tx_next);
                tx_next <= bip_fold(bip, tx_next);
                rcnt    <= 2'd2;
              end
              2'd2: begin
                tx_next <= '0;
                rcnt    <= 2'd3;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign tx_byte    = (phase == PH_RDATA) ? tx_next : '0;
  assign mem_wr_en  = wr_en;
  assign mem_rd_en  = rd_req;
  assign mem_addr   = wr_en ? wr_addr : addr;
  assign mem_wdata  = wr_data;
  assign parity_err = perr;
  assign bip_active = bip_q;
endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
  import spi_regacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_bip,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              parity_err
);
  logic              cs_act, cs_start, sample_evt, shift_evt, mosi_s;
  logic              byte_done, tx_load, bip_active;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  spi_regacc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap      (cfg_mode),
    .sclk       (spi_sclk),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi),
    .cs_act     (cs_act),
    .cs_start   (cs_start),
    .sample_evt (sample_evt),
    .shift_evt  (shift_evt),
    .mosi_s     (mosi_s)
  );

  spi_regacc_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .cs_start   (cs_start),
    .sample_evt (sample_evt),
    .shift_evt  (shift_evt),
    .mosi_s     (mosi_s),
    .tx_byte    (tx_byte),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .tx_load    (tx_load),
    .miso       (spi_miso)
  );

  spi_regacc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .cs_start   (cs_start),
    .bip_mode   (cfg_bip),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .tx_load    (tx_load),
    .mem_rdata  (mem_rdata),
    .mem_wr_en  (mem_wr_en),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .parity_err (parity_err),
    .tx_byte    (tx_byte),
    .bip_active (bip_active)
  );
endmodule

// File: rtl/spi_regacc_chk.sv
module spi_regacc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_cs_n,
  input logic        spi_miso,
  input logic        mem_wr_en,
  input logic        mem_rd_en,
  input logic [15:0] mem_addr,
  input logic        parity_err,
  input logic        bip_active
);
  // R9
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && mem_rd_en));

  // R9
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R5
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);

  // R6
  pair_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr == $past(mem_addr) + 16'd1));

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> !parity_err);

  // R7
  err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> (!mem_wr_en ##1 !mem_wr_en));

  // R7
  err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> bip_active);
endmodule

bind spi_regacc spi_regacc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_cs_n   (spi_cs_n),
  .spi_miso   (spi_miso),
  .mem_wr_en  (mem_wr_en),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .parity_err (parity_err),
  .bip_active (bip_active)
);

// File: tb/spi_regacc_bench.sv
`timescale 1ns/1ps
module spi_regacc_bench;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_bip = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso, mem_wr_en, mem_rd_en, parity_err;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int perr_seen = 0;
  int rd_seen = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
  } wr_item_t;
  wr_item_t wr_q[$];

  always #2.5 clk = ~clk;

  spi_regacc u_spi_regacc (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_bip    (cfg_bip),
    .spi_sclk   (sclk),
    .spi_cs_n   (cs_n),
    .spi_mosi   (mosi),
    .spi_miso   (miso),
    .mem_wr_en  (mem_wr_en),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .parity_err (parity_err)
  );

  function automatic logic [7:0] mem_model(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  // Memory environment: one-cycle read latency (R9)
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_model(mem_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops expected writes as the design produces them
  always @(negedge clk) begin : wr_mon
    wr_item_t it;
    if (rst_n && mem_wr_en) begin
      if (wr_q.size() == 0) begin
        check(1'b0, "R2/R4/R7 unexpected write", {mem_addr, 8'h00, mem_wdata}, 32'h0);
      end else begin
        it = wr_q.pop_front();
        check({mem_addr, mem_wdata} == {it.a, it.d}, "R2/R6 write",
              {8'h00, mem_addr, mem_wdata}, {8'h00, it.a, it.d});
      end
    end
    if (rst_n && parity_err) perr_seen++;
    if (rst_n && mem_rd_en) rd_seen++;
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m, input logic b);
    cfg_mode = m;
    cfg_bip  = b;
    sclk     = m[1];
    ticks(8);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      if (!cfg_mode[0]) begin
        mosi = tx[i];
        ticks(HALF);
        rx[i] = miso;
        sclk = ~cfg_mode[1];
        ticks(HALF);
        sclk = cfg_mode[1];
      end else begin
        sclk = ~cfg_mode[1];
        mosi = tx[i];
        ticks(HALF);
        rx[i] = miso;
        sclk = cfg_mode[1];
        ticks(HALF);
      end
    end
  endtask

  task automatic open_cs();
    sclk = cfg_mode[1];
    ticks(4);
    cs_n = 1'b0;
    ticks(6);
  endtask

  task automatic close_cs();
    ticks(HALF);
    cs_n = 1'b1;
    ticks(12);
  endtask

  task automatic write_stream(input logic [15:0] a, input logic [7:0] seed, input int n);
    logic [7:0] r, d;
    open_cs();
    xfer(8'h02, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 7);
      wr_q.push_back('{a + 16'(i), d});
      xfer(d, r);
    end
    close_cs();
    check(wr_q.size() == 0, "R2 all writes seen", wr_q.size(), 0);
  endtask

  task automatic read_stream(input logic [7:0] cmd, input logic [15:0] a, input int n, input string req);
    logic [7:0] r, e;
    open_cs();
    xfer(cmd, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    xfer(8'hFF, r);
    check(r == 8'h00, {req, " dummy byte R3"}, r, 8'h00);
    for (int i = 0; i < n; i++) begin
      e = mem_model(a + 16'(i));
      xfer(8'h00, r);
      check(r == e, req, r, e);
    end
    close_cs();
  endtask

  task automatic ignored_cmd(input logic [7:0] cmd);
    logic [7:0] r;
    int rd0;
    rd0 = rd_seen;
    open_cs();
    for (int i = 0; i < 5; i++) begin
      xfer((i == 0) ? cmd : 8'hA0 + 8'(i), r);
      check(r == 8'h00, "R4 miso zero", r, 8'h00);
    end
    close_cs();
    check(rd_seen == rd0, "R4 no read", rd_seen, rd0);
  endtask

  task automatic bip_write(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1, input bit bad);
    logic [7:0] r, c;
    int p0;
    p0 = perr_seen;
    c = a[15:8] ^ a[7:0] ^ d0 ^ d1 ^ (bad ? 8'h40 : 8'h00);
    if (!bad) begin
      wr_q.push_back('{a, d0});
      wr_q.push_back('{a + 16'd1, d1});
    end
    open_cs();
    xfer(8'h02, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    xfer(d0, r);
    xfer(d1, r);
    xfer(c, r);
    xfer(8'hEE, r);
    close_cs();
    check(wr_q.size() == 0, "R6 checked write pair", wr_q.size(), 0);
    check(perr_seen == p0 + (bad ? 1 : 0), "R7 error pulses", perr_seen, p0 + (bad ? 1 : 0));
  endtask

  task automatic bip_read(input logic [7:0] cmd, input logic [15:0] a, input logic [7:0] dummy);
    logic [7:0] r, e0, e1, ec;
    e0 = mem_model(a);
    e1 = mem_model(a + 16'd1);
    ec = a[15:8] ^ a[7:0] ^ dummy ^ e0 ^ e1;
    open_cs();
    xfer(cmd, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    xfer(dummy, r);
    xfer(8'h00, r);
    check(r == e0, "R8 first data", r, e0);
    xfer(8'h00, r);
    check(r == e1, "R8 second data", r, e1);
    xfer(8'h00, r);
    check(r == ec, "R8 check byte", r, ec);
    xfer(8'h00, r);
    check(r == 8'h00, "R8 after check", r, 8'h00);
    close_cs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ticks(10);
    rst_n = 1'b1;
    ticks(5);
    // R9 reset state, R5 idle line
    check({mem_wr_en, mem_rd_en, parity_err} == 3'b000, "R9 reset outputs",
          {mem_wr_en, mem_rd_en, parity_err}, 0);
    check(miso == 1'b0, "R5 idle miso", miso, 0);

    set_mode(2'b00, 1'b0);
    write_stream(16'h1234, 8'h11, 4);
    read_stream(8'h03, 16'h1234, 3, "R1/R3 mode0 read 03");
    read_stream(8'h0B, 16'h00FE, 4, "R3 mode0 read 0B across byte");

    set_mode(2'b01, 1'b0);
    write_stream(16'hFFFE, 8'h80, 3);
    read_stream(8'h0B, 16'h2000, 3, "R1 mode1 read");

    set_mode(2'b10, 1'b0);
    write_stream(16'h0400, 8'h5A, 2);
    read_stream(8'h03, 16'h7FFF, 2, "R1 mode2 read");

    set_mode(2'b11, 1'b0);
    write_stream(16'hABCD, 8'h01, 2);
    read_stream(8'h03, 16'hFFFF, 2, "R1/R2 mode3 read wrap");
    ignored_cmd(8'h05);
    ignored_cmd(8'h0A);
    check(miso == 1'b0, "R5 miso low with cs high", miso, 0);

    set_mode(2'b00, 1'b1);
    bip_write(16'h0102, 8'hC3, 8'h3C, 1'b0);
    bip_write(16'h0200, 8'h55, 8'hAA, 1'b1);
    bip_read(8'h03, 16'h0300, 8'h96);

    set_mode(2'b11, 1'b1);
    bip_read(8'h0B, 16'hFF10, 8'h00);
    bip_write(16'h4444, 8'h12, 8'h34, 1'b0);
    bip_write(16'h4446, 8'h00, 8'h00, 1'b1);

    set_mode(2'b01, 1'b0);
    ticks(20);
    check(wr_q.size() == 0, "R2/R6 scoreboard drained", wr_q.size(), 0);
    check(perr_seen == 2, "R7 total error pulses", perr_seen, 2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule